// File: doc/BRIEF.md
# SIMD Vector Branch Condition Unit

This block takes one 32-bit vector-branch instruction word together with the current program counter and a 128-bit vector operand. It decides whether the branch is taken and computes where it goes. A two-bit class input selects the test. Two classes test the whole vector: branch when it is all zero, or branch when any bit is set. The other two classes test lanes at a run-time width of 8, 16, 32 or 64 bits: branch when at least one lane is zero, or branch when no lane is zero.

A flag marks an instruction that sits in a branch delay slot. Such an instruction raises a reserved-instruction exception and is never taken. The results are held in registers and appear one cycle after the valid strobe, marked by a one-cycle result-valid pulse.

A small state machine sequences the result-valid flag. It has two states. ST_IDLE moves to ST_REPORT when the strobe is high. ST_REPORT stays in ST_REPORT while the strobe stays high, and returns to ST_IDLE when the strobe is low. The outputs keep their last values between results.

Top module: `vbranch_cond_unit`

## Requirements
- R1: Instruction bits [22:21] select the lane width for the per-lane classes: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, 3 is 64 bits. The offset is instruction bits [15:0].
- R2: target equals pc + 4 + (sign-extended offset × 4), wrapping modulo 2^32.
- R3: Class 0 (whole-vector zero) is taken exactly when all 128 operand bits are zero.
- R4: Class 1 (whole-vector nonzero) is taken exactly when at least one operand bit is one.
- R5: Class 2 (per-lane zero) is taken exactly when at least one lane of the selected width is zero.
- R6: Class 3 (per-lane nonzero) is taken exactly when every lane of the selected width is nonzero.
- R7: When in_delay_slot is high with the strobe, ri_exc is 1 and taken is 0. Otherwise ri_exc is 0.
- R8: taken, target and ri_exc update on the clock edge that samples in_valid high and hold their values otherwise. res_valid is high in exactly the cycle after each strobe.
- R9: While rst is high at a clock edge, all outputs are cleared to zero, even if in_valid is high.
- R10: For classes 0 and 1, the lane-size field has no effect on taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: evaluate the inputs this cycle |
| instr | input | 32 | Branch instruction word |
| pc | input | 32 | Program counter of the branch |
| vec | input | 128 | Vector operand |
| br_class | input | 2 | 0 whole zero, 1 whole nonzero, 2 lane zero, 3 lane nonzero |
| in_delay_slot | input | 1 | Instruction is in a branch delay slot |
| taken | output | 1 | Branch taken (registered) |
| target | output | 32 | Branch target (registered) |
| ri_exc | output | 1 | Reserved-instruction exception (registered) |
| res_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The hold and pulse assertions assume that the inputs are stable around the clock edge, and that reset, when applied, lasts a full cycle. The bench meets this by changing every input at the falling edge only. The lane-zero check assumes that the 128-bit operand is fully driven whenever a result is formed. The bench therefore always drives a defined value on vec, including in idle cycles. Idle gaps between strobes let the hold behaviour be seen at the ports, and back-to-back strobes exercise the path that stays in the reporting state.

// File: rtl/vbc_pkg.sv
package vbc_pkg;
    typedef enum logic [1:0] {
        CLS_VEC_Z   = 2'd0,
        CLS_VEC_NZ  = 2'd1,
        CLS_LANE_Z  = 2'd2,
        CLS_LANE_NZ = 2'd3
    } br_class_e;

    typedef enum logic [1:0] {
        LS_B8  = 2'd0,
        LS_H16 = 2'd1,
        LS_W32 = 2'd2,
        LS_D64 = 2'd3
    } lane_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } ctl_state_e;

    localparam int INSTR_W  = 32;
    localparam int LS_LSB   = 21;
    localparam int OFFSET_W = 16;
endpackage

// File: rtl/vbc_lane_zero_detect.sv
module vbc_lane_zero_detect
    import vbc_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int SEG_W = 64
) (
    input  logic [VEC_W-1:0] vec,
    input  lane_size_e       lsz,
    output logic             any_lane_zero,
    output logic             all_zero
);
    localparam int NSEG = VEC_W / SEG_W;

    logic [SEG_W-1:0] lsb_mask;
    logic [SEG_W-1:0] top_mask;
    logic [NSEG-1:0]  seg_hit;

    // Masks with a one at the bottom and at the top of every lane
    always_comb begin
        int lw;
        lw = 8 << lsz;
        for (int i = 0; i < SEG_W; i++) begin
            lsb_mask[i] = ((i % lw) == 0);
            top_mask[i] = ((i % lw) == (lw - 1));
        end
    end

    // Borrow trick per segment: a set top bit survives only above a zero lane
    genvar g;
    generate
        for (g = 0; g < NSEG; g++) begin : g_seg
            logic [SEG_W-1:0] seg;
            logic [SEG_W-1:0] dif;
            assign seg        = vec[g*SEG_W +: SEG_W];
            assign dif        = seg - lsb_mask;
            assign seg_hit[g] = |(dif & ~seg & top_mask);
        end
    endgenerate

    assign any_lane_zero = |seg_hit;
    assign all_zero      = ~|vec;

    // R5: an all-zero operand must always show a zero lane
    always_comb begin
        a_r5_zero_vec_has_zero_lane: assert (!all_zero || any_lane_zero);
    end
endmodule

// File: rtl/vbc_target_calc.sv
module vbc_target_calc #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W - 2;

    logic [ADDR_W-1:0] disp;

    assign disp   = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
    assign target = pc + ADDR_W'(4) + disp;

    // R2: displacement is a whole number of words
    always_comb begin
        a_r2_low_bits_kept: assert (target[1:0] == pc[1:0]);
    end
endmodule

// File: rtl/vbc_ctrl.sv
module vbc_ctrl
    import vbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic res_valid
);
    ctl_state_e state_q;
    ctl_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!in_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        res_valid = (state_q == ST_REPORT);
    end
endmodule

// File: rtl/vbranch_cond_unit.sv
module vbranch_cond_unit
    import vbc_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int SEG_W  = 64,
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [VEC_W-1:0]   vec,
    input  logic [1:0]         br_class,
    input  logic               in_delay_slot,
    output logic               taken,
    output logic [ADDR_W-1:0]  target,
    output logic               ri_exc,
    output logic               res_valid
);
    lane_size_e          lsz;
    br_class_e           cls;
    logic [OFFSET_W-1:0] offset;
    logic                lane_zero;
    logic                vec_zero;
    logic                cond;
    logic [ADDR_W-1:0]   tgt_c;
    logic                unused_fields;

    assign lsz           = lane_size_e'(instr[LS_LSB +: 2]);
    assign offset        = instr[OFFSET_W-1:0];
    assign cls           = br_class_e'(br_class);
    assign unused_fields = ^{instr[INSTR_W-1:LS_LSB+2], instr[LS_LSB-1:OFFSET_W]};

    vbc_lane_zero_detect #(.VEC_W(VEC_W), .SEG_W(SEG_W)) u_lanes (
        .vec           (vec),
        .lsz           (lsz),
        .any_lane_zero (lane_zero),
        .all_zero      (vec_zero)
    );

    vbc_target_calc #(.ADDR_W(ADDR_W), .OFF_W(OFFSET_W)) u_tgt (
        .pc     (pc),
        .offset (offset),
        .target (tgt_c)
    );

    vbc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .res_valid (res_valid)
    );

    always_comb begin
        unique case (cls)
            CLS_VEC_Z:   cond = vec_zero;
            CLS_VEC_NZ:  cond = !vec_zero;
            CLS_LANE_Z:  cond = lane_zero;
            CLS_LANE_NZ: cond = !lane_zero;
            default:     cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            taken  <= 1'b0;
            target <= '0;
            ri_exc <= 1'b0;
        end else if (in_valid) begin
            taken  <= cond && !in_delay_slot;
            target <= tgt_c;
            ri_exc <= in_delay_slot;
        end
    end

    a_r7_exc_blocks_taken: assert property (@(posedge clk) disable iff (rst)
        ri_exc |-> !taken);

    a_r7_slot_raises_exc: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_delay_slot) |=> ri_exc);

    a_r7_no_slot_no_exc: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_delay_slot) |=> !ri_exc);

    a_r8_pulse_after_strobe: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(in_valid));

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(taken) && $stable(target) && $stable(ri_exc) && !res_valid));

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!taken && !ri_exc && !res_valid && target == '0));
endmodule

// File: tb/vbranch_cond_unit_tb.sv
module vbranch_cond_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [31:0]  instr;
    logic [31:0]  pc;
    logic [127:0] vec;
    logic [1:0]   br_class;
    logic         in_delay_slot;
    logic         taken;
    logic [31:0]  target;
    logic         ri_exc;
    logic         res_valid;

    int  n_cmp  = 0;
    int  n_bad  = 0;
    bit  done   = 1'b0;
    bit  exp_tk = 1'b0;
    bit  exp_ex = 1'b0;
    logic [31:0] exp_tg = '0;

    always #10 clk = ~clk;

    vbranch_cond_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .pc(pc),
        .vec(vec), .br_class(br_class), .in_delay_slot(in_delay_slot),
        .taken(taken), .target(target), .ri_exc(ri_exc), .res_valid(res_valid)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Reference: walk every lane of the chosen width
    function automatic bit ref_taken(input logic [127:0] v, input int cls, input int ls);
        int  lw;
        bit  some_zero;
        logic [127:0] lane;
        if (cls == 0) return (v == 128'd0);
        if (cls == 1) return (v != 128'd0);
        lw = 8 << ls;
        some_zero = 0;
        for (int k = 0; k < 128 / lw; k++) begin
            lane = v >> (k * lw);
            if (lw < 128) lane = lane & ((128'd1 << lw) - 128'd1);
            if (lane == 128'd0) some_zero = 1;
        end
        return (cls == 2) ? some_zero : !some_zero;
    endfunction

    function automatic logic [31:0] ref_target(input logic [31:0] p, input logic [15:0] off);
        longint s;
        s = longint'($signed(off)) * 4 + longint'(p) + 4;
        return s[31:0];
    endfunction

    task automatic run(input string tag, input int cls, input int ls,
                       input logic [127:0] v, input logic [31:0] p,
                       input logic [15:0] off, input bit ds);
        @(negedge clk);
        instr         = {9'd0, 2'(ls), 5'd7, off};
        pc            = p;
        vec           = v;
        br_class      = 2'(cls);
        in_delay_slot = ds;
        in_valid      = 1'b1;
        exp_tk = ds ? 1'b0 : ref_taken(v, cls, ls);
        exp_ex = ds;
        exp_tg = ref_target(p, off);
        @(negedge clk);
        in_valid = 1'b0;
        chk(tag, "taken", 64'(taken), 64'(exp_tk));
        chk(tag, "target", 64'(target), 64'(exp_tg));
        chk(tag, "ri_exc", 64'(ri_exc), 64'(exp_ex));
        chk("R8", "res_valid", 64'(res_valid), 64'd1);
    endtask

    task automatic idle_check();
        @(negedge clk);
        vec = ~vec;
        pc  = pc + 32'd64;
        @(negedge clk);
        chk("R8", "idle res_valid", 64'(res_valid), 64'd0);
        chk("R8", "held taken", 64'(taken), 64'(exp_tk));
        chk("R8", "held target", 64'(target), 64'(exp_tg));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [127:0] v;
        rst = 1'b1; in_valid = 1'b0; instr = '0; pc = '0; vec = '0;
        br_class = '0; in_delay_slot = 1'b0;
        repeat (2) @(negedge clk);
        // R9: strobe during reset must not load anything
        in_valid = 1'b1; vec = '1; br_class = 2'd1; pc = 32'h100;
        @(negedge clk);
        chk("R9", "taken", 64'(taken), 64'd0);
        chk("R9", "target", 64'(target), 64'd0);
        chk("R9", "ri_exc", 64'(ri_exc), 64'd0);
        chk("R9", "res_valid", 64'(res_valid), 64'd0);
        in_valid = 1'b0; rst = 1'b0;
        @(negedge clk);

        // R3 R4 R10: whole-vector tests at every lane-size value
        for (int ls = 0; ls < 4; ls++) begin
            run("R3", 0, ls, 128'd0, 32'h1000, 16'd3, 0);
            run("R3", 0, ls, 128'd1 << 127, 32'h1000, 16'd3, 0);
            run("R4", 1, ls, 128'd0, 32'h2000, 16'd5, 0);
            run("R10", 1, ls, 128'd1 << (ls * 37), 32'h2000, 16'd5, 0);
        end
        idle_check();

        // R1 R5 R6: one zero lane per width, at every lane position
        for (int ls = 0; ls < 4; ls++) begin
            int lw;
            lw = 8 << ls;
            for (int k = 0; k < 128 / lw; k++) begin
                v = '1;
                for (int b = 0; b < lw; b++) v[k*lw + b] = 1'b0;
                for (int t = 0; t < 4; t++) begin
                    run("R5", 2, t, v, 32'h400, 16'h10, 0);
                    run("R6", 3, t, v, 32'h400, 16'h10, 0);
                end
            end
        end
        // R1: only the top bit of each byte set, then alternating zero bytes
        for (int t = 0; t < 4; t++) begin
            run("R5", 2, t, {16{8'h80}}, 32'h800, 16'h1, 0);
            run("R6", 3, t, {16{8'h80}}, 32'h800, 16'h1, 0);
            run("R1", 2, t, {8{16'h0100}}, 32'h800, 16'h1, 0);
            run("R1", 3, t, {4{32'h00010000}}, 32'h800, 16'h1, 0);
            run("R1", 2, t, {2{64'h0000_0001_0000_0000}}, 32'h800, 16'h1, 0);
        end
        idle_check();

        // R2: offset extremes and wrap-around
        run("R2", 1, 0, 128'd9, 32'h0000_1000, 16'h7FFF, 0);
        run("R2", 1, 0, 128'd9, 32'h0000_1000, 16'h8000, 0);
        run("R2", 1, 0, 128'd9, 32'hFFFF_FFFC, 16'h0000, 0);
        run("R2", 1, 0, 128'd9, 32'hFFFF_FFF0, 16'h7FFF, 0);
        run("R2", 1, 0, 128'd9, 32'h0000_0004, 16'h8000, 0);
        run("R2", 0, 0, 128'd0, 32'h0000_0000, 16'hFFFF, 0);

        // R7: delay-slot branches, even ones whose condition holds
        run("R7", 0, 0, 128'd0, 32'h3000, 16'h20, 1);
        run("R7", 2, 1, 128'd0, 32'h3000, 16'h20, 1);
        run("R7", 3, 3, '1, 32'h3000, 16'h20, 1);
        idle_check();
        run("R7", 3, 3, '1, 32'h3000, 16'h20, 0);

        // R5 R6 R8: mixed stimulus, with back-to-back strobes and gaps
        for (int n = 0; n < 400; n++) begin
            int cls;
            int ls;
            v = {$urandom, $urandom, $urandom, $urandom};
            for (int b = 0; b < 16; b++)
                if (($urandom % 6) == 0) v[b*8 +: 8] = 8'h00;
            if (($urandom % 10) == 0) v = '0;
            cls = int'($urandom % 4);
            ls  = int'($urandom % 4);
            run((cls < 2) ? "R4" : "R5", cls, ls, v, $urandom,
                16'($urandom), (($urandom % 12) == 0));
            if ((n % 7) == 0) idle_check();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule